// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves eight-bit bytes over a single data line in half-duplex fashion, and it always drives the shift clock itself. The data line is split into an output value, an output enable and an input value, so the pad ring can build the bidirectional pin. All timing is counted in cycles of the system clock, and one shift-clock period lasts a fixed number of those cycles.

A host starts a transmit by pulsing the byte-write strobe. The byte then leaves least-significant bit first, one bit per shift-clock period. Each bit is launched a fixed number of cycles after a shift-clock rising edge, so it is stable well before the next rising edge. A host starts a receive by pulsing the receive-done clear strobe while receive is enabled. The port then releases the line and samples it on each shift-clock rising edge. At the end of a transfer the matching done flag rises. For a receive, the assembled byte appears in the read buffer in the same cycle. Both flags stay set until the host clears them.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `shift_clk` is 1, `line_out` is 1, `line_oe` is 0, both done flags are 0 and `rd_data` is 0.
- R2: `shift_clk` idles high. During a transfer it has a period of 12 clock cycles: low for 6 cycles, then high for 6.
- R3: A `wr_stb` pulse while the port is idle starts a transmit. `line_oe` goes to 1 and the 8 bits of `wr_data` appear on `line_out`, bit 0 first, one per shift-clock period. The value present at the k-th rising edge of `shift_clk` is bit k-1.
- R4: Every transmitted bit is valid at least 10 cycles before the shift-clock rising edge that marks it. The first rising edge comes 10 cycles after the clock edge that accepted the write.
- R5: Every transmitted bit is held for 2 cycles after its rising edge, and then the next bit is driven.
- R6: `tx_done` rises 96 cycles after the accepting edge, which is 2 cycles after the eighth rising edge. `line_oe` returns to 0 in that same cycle.
- R7: A `rx_clr` pulse while idle, with `rx_en` at 1, starts a receive. `line_oe` stays 0, `line_in` is captured at each shift-clock rising edge, and the first captured value becomes bit 0. No hold time is needed after the rising edge.
- R8: `rx_done` rises 96 cycles after the accepting edge. In that same cycle `rd_data` shows the eight captured bits.
- R9: A `rx_clr` pulse with `rx_en` at 0 clears `rx_done` but starts no transfer. `shift_clk` stays high, `line_oe` stays 0 and `rd_data` is unchanged.
- R10: A `wr_stb` pulse or a receive-start request that arrives during a transfer is ignored, and the ongoing transfer continues unchanged.
- R11: A done flag stays at 1 until its own clear strobe (`tx_clr` or `rx_clr`) or reset. The clear takes effect on the next clock edge, even during a transfer.
- R12: If `wr_stb` and a receive-start request arrive in the same idle cycle, the transmit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Byte-write strobe, starts a transmit |
| wr_data | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| rx_clr | input | 1 | Clears `rx_done`; starts a receive when `rx_en` is 1 |
| tx_clr | input | 1 | Clears `tx_done` |
| rd_data | output | 8 | Last received byte |
| tx_done | output | 1 | Transmit-complete flag |
| rx_done | output | 1 | Receive-complete flag |
| shift_clk | output | 1 | Shift clock driven by the port |
| line_out | output | 1 | Data line output value |
| line_oe | output | 1 | Data line output enable |
| line_in | input | 1 | Data line input value |

## Verification
The bench builds the port with its default parameters: a 12-cycle shift period with 6 low cycles, a 2-cycle launch delay and 8-bit bytes. With these values one transfer takes 96 cycles, so the bench can step through every transfer cycle by cycle against a model it computes itself. That reaches the setup window before each edge, the two-cycle hold after it, and the exact cycle in which each flag rises. The receive stimulus changes `line_in` in the cycle right after each sampling edge, which exercises the zero-hold rule. Mid-transfer strobes and the simultaneous-start case check that a running transfer cannot be disturbed.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int SSP_DIV   = 12;
    localparam int SSP_LOW   = 6;
    localparam int SSP_HOLD  = 2;
    localparam int SSP_WIDTH = 8;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2
    } ssp_mode_e;

    // Per-cycle events produced by the timebase
    typedef struct packed {
        logic rise;    // shift clock goes high on this edge
        logic launch;  // bit boundary: next output bit is driven on this edge
    } ssp_tick_t;

    function automatic logic [7:0] wrap_inc(input logic [7:0] v, input int unsigned top);
        return (v == 8'(top - 1)) ? 8'd0 : v + 8'd1;
    endfunction

endpackage

// File: rtl/ssp_timebase.sv
module ssp_timebase
    import ssp_pkg::*;
#(
    parameter int DIV     = SSP_DIV,
    parameter int LOW_CYC = SSP_LOW,
    parameter int HOLD    = SSP_HOLD
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      active,
    output logic      sclk,
    output ssp_tick_t tick
);
    localparam int LAUNCH = LOW_CYC + HOLD;

    logic [7:0] phase_q;
    logic [7:0] phase_n;

    always_comb begin
        phase_n     = wrap_inc(phase_q, DIV);
        tick.rise   = active && (phase_n == 8'(LOW_CYC));
        tick.launch = active && (phase_n == 8'(LAUNCH));
    end

    // A start parks the phase at the launch point, so the first bit
    // gets the same setup window as every later one.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 8'(LAUNCH);
            sclk    <= 1'b1;
        end else if (start) begin
            phase_q <= 8'(LAUNCH);
            sclk    <= 1'b1;
        end else if (active) begin
            phase_q <= phase_n;
            sclk    <= (phase_n >= 8'(LOW_CYC));
        end else begin
            sclk    <= 1'b1;
        end
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             tx_shift,
    input  logic             rx_cap,
    input  logic             release_line,
    input  logic             line_in,
    output logic [WIDTH-1:0] shreg,
    output logic             line_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            line_out <= 1'b1;
        end else if (load) begin
            shreg    <= load_data;
            line_out <= load_data[0];
        end else if (release_line) begin
            line_out <= 1'b1;
        end else if (tx_shift) begin
            shreg    <= shreg >> 1;
            line_out <= shreg[1];
        end else if (rx_cap) begin
            shreg    <= {line_in, shreg[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int WIDTH = SSP_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic             rx_en,
    input  logic             rx_clr,
    input  logic             tx_clr,
    input  ssp_tick_t        tick,
    input  logic [WIDTH-1:0] shreg,
    output logic             start_tx,
    output logic             start_rx,
    output logic             active,
    output logic             tx_shift,
    output logic             rx_cap,
    output logic             finish,
    output logic             line_oe,
    output logic             tx_done,
    output logic             rx_done,
    output logic [WIDTH-1:0] rd_data
);
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    ssp_mode_e      mode_q;
    logic [BW-1:0]  bit_q;
    logic           idle;
    logic           last;

    always_comb begin
        idle     = (mode_q == MODE_IDLE);
        active   = !idle;
        last     = (bit_q == BW'(WIDTH - 1));
        start_tx = idle && wr_stb;
        start_rx = idle && !wr_stb && rx_clr && rx_en;
        finish   = active && tick.launch && last;
        tx_shift = (mode_q == MODE_TX) && tick.launch && !last;
        rx_cap   = (mode_q == MODE_RX) && tick.rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_IDLE;
            bit_q   <= '0;
            line_oe <= 1'b0;
        end else if (start_tx) begin
            mode_q  <= MODE_TX;
            bit_q   <= '0;
            line_oe <= 1'b1;
        end else if (start_rx) begin
            mode_q  <= MODE_RX;
            bit_q   <= '0;
            line_oe <= 1'b0;
        end else if (finish) begin
            mode_q  <= MODE_IDLE;
            line_oe <= 1'b0;
        end else if (active && tick.launch) begin
            bit_q   <= bit_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_done <= 1'b0;
            rx_done <= 1'b0;
            rd_data <= '0;
        end else begin
            if (finish && mode_q == MODE_TX) tx_done <= 1'b1;
            else if (tx_clr)                 tx_done <= 1'b0;
            if (finish && mode_q == MODE_RX) begin
                rx_done <= 1'b1;
                rd_data <= shreg;
            end else if (rx_clr) begin
                rx_done <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DIV     = SSP_DIV,
    parameter int LOW_CYC = SSP_LOW,
    parameter int HOLD    = SSP_HOLD,
    parameter int WIDTH   = SSP_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rx_en,
    input  logic             rx_clr,
    input  logic             tx_clr,
    output logic [WIDTH-1:0] rd_data,
    output logic             tx_done,
    output logic             rx_done,
    output logic             shift_clk,
    output logic             line_out,
    output logic             line_oe,
    input  logic             line_in
);
    ssp_tick_t        tick_w;
    logic             start_tx_w;
    logic             start_rx_w;
    logic             busy_w;
    logic             tx_shift_w;
    logic             rx_cap_w;
    logic             finish_w;
    logic [WIDTH-1:0] shreg_w;

    ssp_timebase #(.DIV(DIV), .LOW_CYC(LOW_CYC), .HOLD(HOLD)) u_timebase (
        .clk    (clk),
        .rst    (rst),
        .start  (start_tx_w | start_rx_w),
        .active (busy_w),
        .sclk   (shift_clk),
        .tick   (tick_w)
    );

    ssp_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .rx_en    (rx_en),
        .rx_clr   (rx_clr),
        .tx_clr   (tx_clr),
        .tick     (tick_w),
        .shreg    (shreg_w),
        .start_tx (start_tx_w),
        .start_rx (start_rx_w),
        .active   (busy_w),
        .tx_shift (tx_shift_w),
        .rx_cap   (rx_cap_w),
        .finish   (finish_w),
        .line_oe  (line_oe),
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .rd_data  (rd_data)
    );

    ssp_shifter #(.WIDTH(WIDTH)) u_shifter (
        .clk          (clk),
        .rst          (rst),
        .load         (start_tx_w),
        .load_data    (wr_data),
        .tx_shift     (tx_shift_w),
        .rx_cap       (rx_cap_w),
        .release_line (finish_w),
        .line_in      (line_in),
        .shreg        (shreg_w),
        .line_out     (line_out)
    );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int DIV     = 12,
    parameter int LOW_CYC = 6,
    parameter int HOLD    = 2
) (
    input logic clk,
    input logic rst,
    input logic shift_clk,
    input logic line_out,
    input logic line_oe,
    input logic tx_done,
    input logic rx_done,
    input logic active
);
    localparam int SETUP = DIV - HOLD;

    logic        prev_out;
    logic        prev_clk;
    logic [15:0] run_q;
    logic [15:0] run_now;
    logic [15:0] gap_q;
    logic        seen_q;
    logic        rise;

    always_comb begin
        rise    = shift_clk && !prev_clk;
        run_now = (line_out == prev_out) ? run_q + 16'd1 : 16'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_out <= 1'b1;
            prev_clk <= 1'b1;
            run_q    <= 16'd1;
            gap_q    <= '0;
            seen_q   <= 1'b0;
        end else begin
            prev_out <= line_out;
            prev_clk <= shift_clk;
            run_q    <= (run_now == 16'hFFFF) ? run_q : run_now;
            gap_q    <= rise ? 16'd0 : ((gap_q == 16'hFFFF) ? gap_q : gap_q + 16'd1);
            seen_q   <= active ? (seen_q | rise) : 1'b0;
        end
    end

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !active |-> shift_clk);

    assert_period_R2: assert property (@(posedge clk) disable iff (rst)
        rise && seen_q |-> (gap_q + 16'd1 == 16'(DIV)));

    assert_setup_R4: assert property (@(posedge clk) disable iff (rst)
        rise && line_oe |-> (run_now >= 16'(SETUP + 1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        rise && line_oe |=> $stable(line_out));

    assert_tx_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> !line_oe);

    assert_rx_end_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> (shift_clk && !line_oe));
endmodule

bind sync_shift_port ssp_checker #(.DIV(DIV), .LOW_CYC(LOW_CYC), .HOLD(HOLD)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .shift_clk (shift_clk),
    .line_out  (line_out),
    .line_oe   (line_oe),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .active    (busy_w)
);

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 12;
    localparam int LOWC  = 6;
    localparam int HOLD  = 2;
    localparam int W     = 8;
    localparam int XFER  = DIV * W;
    localparam int LAUNCH = LOWC + HOLD;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_stb = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rx_en = 1'b0;
    logic         rx_clr = 1'b0;
    logic         tx_clr = 1'b0;
    logic [W-1:0] rd_data;
    logic         tx_done;
    logic         rx_done;
    logic         shift_clk;
    logic         line_out;
    logic         line_oe;
    logic         line_in = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_shift_port #(.DIV(DIV), .LOW_CYC(LOWC), .HOLD(HOLD), .WIDTH(W)) dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .rx_en(rx_en),
        .rx_clr(rx_clr), .tx_clr(tx_clr), .rd_data(rd_data), .tx_done(tx_done),
        .rx_done(rx_done), .shift_clk(shift_clk), .line_out(line_out),
        .line_oe(line_oe), .line_in(line_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_sclk(input int j);
        return (j >= XFER) ? 1'b1 : (((LAUNCH + j) % DIV) >= LOWC);
    endfunction

    task automatic test_reset();
        check(shift_clk == 1'b1 && line_out == 1'b1, "R1 clk/line", {shift_clk, line_out}, 3);
        check(line_oe == 1'b0, "R1 oe", line_oe, 0);
        check(tx_done == 1'b0 && rx_done == 1'b0, "R1 flags", {tx_done, rx_done}, 0);
        check(rd_data == '0, "R1 rd_data", rd_data, 0);
    endtask

    // Transmit; optional mid-transfer strobes to test R10
    task automatic test_tx(input logic [W-1:0] d, input bit poke);
        int e2 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0;
        @(negedge clk); tx_clr = 1'b1;
        @(negedge clk); tx_clr = 1'b0; wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
        for (int j = 0; j <= XFER; j++) begin
            if (j > 0) @(negedge clk);
            if (poke && j == 31) begin wr_stb = 1'b0; rx_clr = 1'b0; rx_en = 1'b0; end
            if (shift_clk !== exp_sclk(j)) e2++;
            if (line_oe !== (j < XFER)) e6++;
            if (j < XFER && line_out !== d[j / DIV]) begin
                if (j % DIV == LOWC + DIV - LAUNCH) e3++;        // value at rising edge
                else if (j % DIV > LOWC + DIV - LAUNCH) e5++;    // hold cycle after edge
                else e4++;                                       // setup window
            end
            if (j == XFER - 1 && tx_done !== 1'b0) e6++;
            if (j == XFER && tx_done !== 1'b1) e6++;
            if (poke && j == 30) begin
                wr_stb = 1'b1; wr_data = ~d; rx_en = 1'b1; rx_clr = 1'b1;
            end
        end
        check(e2 == 0, "R2 shift clock pattern", e2, 0);
        check(e3 == 0, "R3 bit at rising edge", e3, 0);
        check(e4 == 0, "R4 setup window", e4, 0);
        check(e5 == 0, "R5 hold after edge", e5, 0);
        check(e6 == 0, "R6 done/oe timing", e6, 0);
        if (poke) check(e2 + e3 + e4 + e5 + e6 == 0, "R10 strobes ignored", e2 + e3 + e4 + e5 + e6, 0);
    endtask

    task automatic test_rx(input logic [W-1:0] d);
        int e2 = 0, e7 = 0, e8 = 0;
        rx_en = 1'b1;
        @(negedge clk); rx_clr = 1'b1; line_in = d[0];
        @(negedge clk); rx_clr = 1'b0;
        for (int j = 0; j <= XFER; j++) begin
            if (j > 0) @(negedge clk);
            if (shift_clk !== exp_sclk(j)) e2++;
            if (line_oe !== 1'b0) e7++;
            if (j < XFER && rx_done !== 1'b0) e8++;
            if (j == XFER && (rx_done !== 1'b1 || rd_data !== d)) e8++;
            // changes right after each sampling edge: no hold needed (R7)
            line_in = d[((j + 2) / DIV) % W];
        end
        check(e2 == 0, "R2 shift clock in receive", e2, 0);
        check(e7 == 0, "R7 line released", e7, 0);
        check(e8 == 0 && rd_data == d, "R8 receive result", rd_data, d);
        rx_en = 1'b0;
    endtask

    task automatic test_flags();
        logic [W-1:0] held;
        repeat (25) @(negedge clk);
        check(tx_done == 1'b1 && rx_done == 1'b1, "R11 flags persist", {tx_done, rx_done}, 3);
        tx_clr = 1'b1; @(negedge clk); tx_clr = 1'b0;
        check(tx_done == 1'b0 && rx_done == 1'b1, "R11 tx clear only", {tx_done, rx_done}, 1);
        held = rd_data;
        rx_en = 1'b0; rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
        begin
            int bad = 0;
            for (int k = 0; k < 30; k++) begin
                if (shift_clk !== 1'b1 || line_oe !== 1'b0) bad++;
                @(negedge clk);
            end
            check(rx_done == 1'b0, "R9 rx_done cleared", rx_done, 0);
            check(bad == 0 && rd_data == held, "R9 no receive", bad, 0);
        end
    endtask

    task automatic test_both();
        @(negedge clk); wr_stb = 1'b1; wr_data = 8'h5A; rx_en = 1'b1; rx_clr = 1'b1;
        @(negedge clk); wr_stb = 1'b0; rx_en = 1'b0; rx_clr = 1'b0;
        check(line_oe == 1'b1, "R12 transmit wins", line_oe, 1);
        repeat (XFER) @(negedge clk);
        check(tx_done == 1'b1 && rx_done == 1'b0, "R12 completes as transmit", {tx_done, rx_done}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_tx(8'hA5, 1'b0);
        test_tx(8'h3C, 1'b1);
        test_rx(8'h96);
        test_rx(8'h01);
        test_flags();
        test_both();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule